// File: doc/BRIEF.md
# Serial Register-Access Slave for a Timekeeping Register Space

This block is the serial front end of a small timekeeping macro. An external SPI master opens a transaction by raising chip select and sends one command byte. Its upper bit picks the direction and its lower seven bits are the starting register. Every byte after that is written to, or read from, the next register in turn until chip select falls. The block holds the control register, the charger-configuration register and a 96-byte general-purpose RAM itself. It forwards accesses to the clock, alarm and status registers over a simple internal port, for the counting and matching logic that owns them.

The SPI pins are brought into the system clock domain through a synchronizer. Edges of the serial clock are detected there. A four-state machine frames each transaction:

- `ST_IDLE`: chip select is low and MISO is not driven. Rising chip select moves to `ST_ADDR`.
- `ST_ADDR`: the command byte is shifted in. At its eighth falling SCK edge, a set bit 7 moves to `ST_WRITE` and a clear bit 7 moves to `ST_READ`.
- `ST_WRITE` and `ST_READ`: these stream bytes until chip select falls.

From any state, a low chip select returns to `ST_IDLE`. Control bit 6 is a write-protect lock. While it is set, only the control register accepts writes.

Top module: `spi_regif_slave`

## Requirements
- R1: A transaction starts when `spi_cs` (active high) rises. Its first byte is a command. Bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 are the starting register address.
- R2: The serial mode has SCK idle low, data MSB first. MOSI is captured on the falling SCK edge. MISO changes on the rising SCK edge, so each read bit is valid at the following falling edge.
- R3: After the command byte, each further byte accesses the next address, for any number of bytes, in either direction.
- R4: Addresses 0x00–0x0E and 0x10 belong to the external port. A write gives a one-cycle `ext_wr_en` pulse with `ext_addr`/`ext_wdata`, and a read returns `ext_rdata`. Address 0x0F is the control register (`ctrl_o`), 0x11 the charger register (`charger_o`), and 0x20–0x7F the internal RAM.
- R5: A burst that passes address 0x7F continues at 0x20.
- R6: Addresses 0x12–0x1F read as 0x00, and writes to them change nothing.
- R7: While control bit 6 is 1, writes to every address except 0x0F are ignored. A write to 0x0F is always accepted, including within the same burst that sets the bit.
- R8: Control bits 5:3 always read as 0. Status (0x10) bits 7:2 read as 0, whatever the external port returns.
- R9: `spi_miso_oe` is 1 only during a transaction. It is 0 within three clock cycles of `spi_cs` falling.
- R10: A byte cut short by chip select falling is never written. The next transaction begins again with a command byte.
- R11: After reset, `ctrl_o` = 0x00, `charger_o` = 0x00, `spi_miso_oe` = 0 and all RAM bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| ext_addr | output | 7 | Current register pointer toward the external registers |
| ext_wr_en | output | 1 | One-cycle write strobe for the external registers |
| ext_wdata | output | 8 | Write data for the external registers |
| ext_rdata | input | 8 | Read data of the external register at `ext_addr` |
| ctrl_o | output | 8 | Control register contents |
| charger_o | output | 8 | Charger-configuration register contents |

## Verification
The bench keeps a behavioural register image and drives several kinds of transaction:
- Single-byte accesses show that the command decode and direction bit work.
- Multi-byte bursts through the clock registers and across the control/status/charger boundary show that the auto-increment is correct. They also show the reserved-bit masking.
- A burst that writes the lock bit partway through separates a write-protect check made per byte from one made once per transaction.
- A burst over the top of RAM and a sweep through the unmapped gap show that the pointer wraps correctly and that holes read back as zero.
- Chip select dropped mid-byte, both in a data byte and in the command byte, tells apart a design that commits partial bytes or keeps stale framing.

// File: rtl/spi_regif_pkg.sv
`timescale 1ns/1ps
package spi_regif_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ
    } xfer_state_t;

    localparam logic [6:0] A_EXT_LAST = 7'h0E;
    localparam logic [6:0] A_CTRL     = 7'h0F;
    localparam logic [6:0] A_STAT     = 7'h10;
    localparam logic [6:0] A_CHRG     = 7'h11;
    localparam int         WP_BIT     = 6;
    localparam logic [7:0] CTRL_KEEP  = 8'hC7;
    localparam logic [7:0] STAT_KEEP  = 8'h03;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sck,
    input  logic pin_cs,
    input  logic pin_mosi,
    output logic cs_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    // bit 2 = sck, bit 1 = cs, bit 0 = mosi
    logic [STAGES-1:0][2:0] stg;
    logic                   sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg   <= '0;
            sck_d <= 1'b0;
        end else begin
            stg[0] <= {pin_sck, pin_cs, pin_mosi};
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            sck_d <= stg[STAGES-1][2];
        end
    end

    always_comb begin
        cs_s     = stg[STAGES-1][1];
        mosi_s   = stg[STAGES-1][0];
        sck_rise = stg[STAGES-1][2] & ~sck_d;
        sck_fall = ~stg[STAGES-1][2] & sck_d;
    end
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank
    import spi_regif_pkg::*;
#(
    parameter int         RAM_BASE  = 32,
    parameter int         RAM_DEPTH = 96,
    parameter logic [7:0] CTRL_RST  = 8'h00,
    parameter logic [7:0] CHRG_RST  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] acc_addr,
    input  logic       wr_fire,
    input  logic [7:0] wr_data,
    input  logic [7:0] ext_rdata,
    output logic [7:0] rd_data,
    output logic       ext_wr_en,
    output logic [7:0] ctrl_q,
    output logic [7:0] chrg_q
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);

    logic [7:0]        ram [RAM_DEPTH];
    int unsigned       addr_i;
    logic              in_ram, in_ext, is_ctrl, is_chrg, is_stat, wr_ok;
    logic [RAM_AW-1:0] ram_idx;

    always_comb begin
        addr_i  = int'(acc_addr);
        in_ram  = (addr_i >= RAM_BASE) && (addr_i < RAM_BASE + RAM_DEPTH);
        ram_idx = RAM_AW'(addr_i - RAM_BASE);
        is_ctrl = (acc_addr == A_CTRL);
        is_chrg = (acc_addr == A_CHRG);
        is_stat = (acc_addr == A_STAT);
        in_ext  = (acc_addr <= A_EXT_LAST) || is_stat;
        // lock bit gates everything but the register that holds it
        wr_ok     = wr_fire && (!ctrl_q[WP_BIT] || is_ctrl);
        ext_wr_en = wr_ok && in_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST & CTRL_KEEP;
            chrg_q <= CHRG_RST;
        end else if (wr_ok) begin
            if (is_ctrl) ctrl_q <= wr_data & CTRL_KEEP;
            if (is_chrg) chrg_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= 8'h00;
        end else if (wr_ok && in_ram) begin
            ram[ram_idx] <= wr_data;
        end
    end

    always_comb begin
        if (in_ram)       rd_data = ram[ram_idx];
        else if (is_ctrl) rd_data = ctrl_q;
        else if (is_chrg) rd_data = chrg_q;
        else if (is_stat) rd_data = ext_rdata & STAT_KEEP;
        else if (in_ext)  rd_data = ext_rdata;
        else              rd_data = 8'h00;
    end
endmodule

// File: rtl/spi_regif_slave.sv
`timescale 1ns/1ps
module spi_regif_slave
    import spi_regif_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         RAM_BASE    = 32,
    parameter int         RAM_DEPTH   = 96,
    parameter logic [7:0] CTRL_RST    = 8'h00,
    parameter logic [7:0] CHRG_RST    = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic [6:0] ext_addr,
    output logic       ext_wr_en,
    output logic [7:0] ext_wdata,
    input  logic [7:0] ext_rdata,
    output logic [7:0] ctrl_o,
    output logic [7:0] charger_o
);
    localparam logic [6:0] RAM_FIRST_A = 7'(RAM_BASE);
    localparam logic [6:0] RAM_LAST_A  = 7'(RAM_BASE + RAM_DEPTH - 1);

    xfer_state_t state, state_nx;
    logic        cs_s, mosi_s, sck_rise, sck_fall;
    logic [2:0]  bit_cnt;
    logic [6:0]  rx_sh;
    logic [7:0]  rx_byte, tx_sh, rd_data;
    logic [6:0]  ptr;
    logic        miso_q, ld_pend, byte_done, wr_fire;

    function automatic logic [6:0] step_addr(input logic [6:0] a);
        return (a == RAM_LAST_A) ? RAM_FIRST_A : a + 7'd1;
    endfunction

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sck  (spi_sck),
        .pin_cs   (spi_cs),
        .pin_mosi (spi_mosi),
        .cs_s     (cs_s),
        .mosi_s   (mosi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_reg_bank #(
        .RAM_BASE  (RAM_BASE),
        .RAM_DEPTH (RAM_DEPTH),
        .CTRL_RST  (CTRL_RST),
        .CHRG_RST  (CHRG_RST)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (ptr),
        .wr_fire   (wr_fire),
        .wr_data   (rx_byte),
        .ext_rdata (ext_rdata),
        .rd_data   (rd_data),
        .ext_wr_en (ext_wr_en),
        .ctrl_q    (ctrl_o),
        .chrg_q    (charger_o)
    );

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = sck_fall && (state != ST_IDLE) && (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_s) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (!cs_s)          state_nx = ST_IDLE;
                else if (byte_done) state_nx = rx_byte[7] ? ST_WRITE : ST_READ;
            end
            ST_WRITE: if (!cs_s) state_nx = ST_IDLE;
            ST_READ:  if (!cs_s) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        spi_miso_oe = (state != ST_IDLE);
        spi_miso    = miso_q;
        wr_fire     = byte_done && (state == ST_WRITE);
        ext_addr    = ptr;
        ext_wdata   = rx_byte;
    end

    // shifters and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= 3'd0;
            rx_sh   <= 7'd0;
            tx_sh   <= 8'd0;
            ptr     <= 7'd0;
            miso_q  <= 1'b0;
            ld_pend <= 1'b0;
        end else if (!cs_s || state == ST_IDLE) begin
            bit_cnt <= 3'd0;
            miso_q  <= 1'b0;
            ld_pend <= 1'b0;
        end else begin
            if (sck_fall) begin
                rx_sh   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    unique case (state)
                        ST_ADDR: begin
                            ptr     <= rx_byte[6:0];
                            ld_pend <= ~rx_byte[7];
                        end
                        ST_WRITE: ptr <= step_addr(ptr);
                        ST_READ: begin
                            ptr     <= step_addr(ptr);
                            ld_pend <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (ld_pend) begin
                tx_sh   <= rd_data;
                ld_pend <= 1'b0;
            end else if (sck_rise && state == ST_READ) begin
                miso_q <= tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_regif_checker.sv
`timescale 1ns/1ps
module spi_regif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs,
    input logic       spi_miso_oe,
    input logic [6:0] ext_addr,
    input logic       ext_wr_en,
    input logic [7:0] ctrl_o,
    input logic [7:0] charger_o
);
    logic [2:0] cs_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cs_low_cnt <= 3'd0;
        else if (spi_cs)          cs_low_cnt <= 3'd0;
        else if (cs_low_cnt != 7) cs_low_cnt <= cs_low_cnt + 3'd1;
    end

    a_r9_oe_off_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low_cnt >= 3'd4) |-> !spi_miso_oe);

    a_r4_ext_write_range: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_en |-> ((ext_addr <= 7'h0E) || (ext_addr == 7'h10)));

    a_r4_ext_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_en |=> !ext_wr_en);

    a_r7_lock_blocks_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_en |-> !ctrl_o[6]);

    a_r7_lock_holds_charger: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(charger_o) |-> !$past(ctrl_o[6]));

    a_r8_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[5:3] == 3'b000);

    a_r10_no_write_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low_cnt >= 3'd4) |-> !ext_wr_en);
endmodule

bind spi_regif_slave spi_regif_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs      (spi_cs),
    .spi_miso_oe (spi_miso_oe),
    .ext_addr    (ext_addr),
    .ext_wr_en   (ext_wr_en),
    .ctrl_o      (ctrl_o),
    .charger_o   (charger_o)
);

// File: tb/test_spi_regif_slave.sv
`timescale 1ns/1ps
module test_spi_regif_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sck = 1'b0, cs = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe, ext_wr_en;
    logic [6:0] ext_addr;
    logic [7:0] ext_wdata, ext_rdata, ctrl_o, charger_o;

    int checks = 0, errors = 0, mon_err = 0, cs_low = 0;
    logic [7:0] ext_mem [0:16];
    logic [7:0] mdl [0:127];
    logic [7:0] wq [$];

    always #2.5 clk = ~clk;

    spi_regif_slave i_spi_regif_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs(cs), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .ext_addr(ext_addr),
        .ext_wr_en(ext_wr_en), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ctrl_o(ctrl_o), .charger_o(charger_o)
    );

    // neighbour logic stand-in for the clock/alarm/status registers
    always_comb ext_rdata = (ext_addr <= 7'h10) ? ext_mem[ext_addr[4:0]] : 8'h00;
    always @(posedge clk) if (ext_wr_en && ext_addr <= 7'h10) ext_mem[ext_addr[4:0]] <= ext_wdata;

    // per-clock monitor: when idle, register outputs track the model (R7, R8), MISO released (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            cs_low = cs ? 0 : cs_low + 1;
            if (cs_low >= 4) begin
                if (miso_oe) mon_err++;
                if (ctrl_o !== mdl[15] || charger_o !== mdl[17]) mon_err++;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] mdl_next(input logic [6:0] a);
        return (a == 7'h7F) ? 7'h20 : a + 7'd1;
    endfunction

    function automatic logic [7:0] mdl_read(input logic [6:0] a);
        if (a == 7'h10) return mdl[a] & 8'h03;
        if (a >= 7'h12 && a <= 7'h1F) return 8'h00;
        return mdl[a];
    endfunction

    task automatic mdl_write(input logic [6:0] a, input logic [7:0] d);
        if (mdl[15][6] && a != 7'h0F) return;
        if (a >= 7'h12 && a <= 7'h1F) return;
        mdl[a] = (a == 7'h0F) ? (d & 8'hC7) : d;
    endtask

    task automatic clk_wait(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            @(posedge clk); #1;
            mosi = tx[b];
            sck  = 1'b1;
            clk_wait(HALF); #1;
            rx[b] = miso;
            sck   = 1'b0;
            clk_wait(HALF);
        end
    endtask

    task automatic cs_on;
        @(posedge clk); #1; cs = 1'b1; clk_wait(4);
    endtask

    task automatic cs_off;
        clk_wait(4); #1; cs = 1'b0; clk_wait(10);
    endtask

    task automatic do_write(input logic [6:0] a);
        logic [7:0] r;
        logic [6:0] p;
        p = a;
        cs_on();
        spi_byte({1'b1, a}, 8, r);
        foreach (wq[i]) begin
            spi_byte(wq[i], 8, r);
            mdl_write(p, wq[i]);
            p = mdl_next(p);
        end
        cs_off();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input string tag);
        logic [7:0] r;
        logic [6:0] p;
        p = a;
        cs_on();
        spi_byte({1'b0, a}, 8, r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, 8, r);
            chk($sformatf("%s @%02h", tag, p), r, mdl_read(p));
            p = mdl_next(p);
        end
        cs_off();
    endtask

    task automatic finish_run;
        checks++;
        if (mon_err != 0) begin
            errors++;
            $display("FAIL R9/R7 idle monitor: actual %0d mismatches expected 0", mon_err);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        clk_wait(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 17; i++) ext_mem[i] = 8'h00;
        for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
        clk_wait(5);
        #1 rst_n = 1'b1;
        clk_wait(5);

        // R11 reset state
        chk("R11 ctrl after reset", ctrl_o, 8'h00);
        chk("R11 charger after reset", charger_o, 8'h00);
        chk("R11 oe after reset", {7'd0, miso_oe}, 8'h00);
        do_read(7'h20, 2, "R11 RAM after reset");

        // R1 single-byte write then read, internal charger register
        wq = {8'h5A};
        do_write(7'h11);
        chk("R1 R4 charger_o", charger_o, 8'h5A);
        do_read(7'h11, 1, "R1 R2 charger read");

        // R3 burst over the clock registers, R4 external port
        wq = {8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
        do_write(7'h00);
        chk("R4 ext_mem[3]", ext_mem[3], 8'h07);
        chk("R4 ext_mem[6]", ext_mem[6], 8'h99);
        do_read(7'h00, 7, "R3 R2 burst read");

        // R8 status masking, charger rewrite
        wq = {8'hFF, 8'h3C};
        do_write(7'h10);
        chk("R4 status stored raw", ext_mem[16], 8'hFF);
        do_read(7'h10, 2, "R8 status mask");

        // R7 lock set inside a burst: later bytes dropped; R8 ctrl mask
        wq = {8'h81, 8'hFF, 8'h77, 8'h66};
        do_write(7'h0E);
        chk("R8 ctrl_o masked", ctrl_o, 8'hC7);
        chk("R7 status untouched", ext_mem[16], 8'hFF);
        do_read(7'h0E, 4, "R7 R8 boundary read");

        // R7 locked writes to RAM and clock ignored, control still writable
        wq = {8'h11};
        do_write(7'h30);
        wq = {8'h22};
        do_write(7'h01);
        do_read(7'h30, 1, "R7 locked RAM");
        do_read(7'h01, 1, "R7 locked clock");
        wq = {8'h00};
        do_write(7'h0F);
        chk("R7 unlock via ctrl", ctrl_o, 8'h00);
        wq = {8'h11};
        do_write(7'h30);
        do_read(7'h30, 1, "R7 unlocked RAM");

        // R5 wrap at top of RAM
        wq = {8'hA1, 8'hA2, 8'hA3};
        do_write(7'h7E);
        do_read(7'h7E, 3, "R5 wrap read");
        do_read(7'h20, 1, "R5 wrapped byte");

        // R6 unmapped gap
        wq = {8'hAA, 8'hBB};
        do_write(7'h15);
        do_read(7'h11, 16, "R6 gap sweep");

        // R10 partial data byte
        wq = {8'h5C};
        do_write(7'h40);
        cs_on();
        spi_byte(8'hC0, 8, r);
        spi_byte(8'hFF, 5, r);
        cs_off();
        do_read(7'h40, 1, "R10 partial data");

        // R10 partial command byte, then fresh framing; R9 oe during transfer
        cs_on();
        spi_byte(8'hFF, 3, r);
        cs_off();
        cs_on();
        spi_byte(8'h40, 8, r);
        chk("R9 oe active", {7'd0, miso_oe}, 8'h01);
        spi_byte(8'h00, 8, r);
        chk("R10 read after abort", r, 8'h5C);
        cs_off();
        chk("R9 oe released", {7'd0, miso_oe}, 8'h00);

        finish_run();
    end
endmodule